// File: doc/BRIEF.md
# Memory-Mapped Peripheral Address Decoder

This block sits on a processor's data bus where a plain RAM would otherwise be. An address register captures an address from the bus. It has no path back onto the bus. Fixed comparators then classify that address as one of three things: a word of the memory array, one of eight device slots placed directly above a fixed device base, or nothing at all.

A bus write is steered by the comparator result. Depending on the address, it becomes a write to the memory array, a write to a device register, or no action. A bus read returns the selected word through a multiplexer in the same cycle as the store request, so the value can be driven straight onto the bus. Reads of unmapped addresses return zero.

The device slots model a small display, pointer and text console. There are three pixel registers (X, Y, colour), two pointer coordinates and a key code that come from outside, a screen-clear command and a terminal character. Writing either of the last two also raises a one-cycle pulse toward the device. At full size the memory window is 8M words (`MEM_WORDS = 2**23`) and the devices sit at 0x800000 to 0x800007. The default parameter keeps the array small for elaboration, and the addresses between the end of memory and the device base are then unmapped.

Top module: `mmio_decoder`

## Requirements
- R1: When `addr_load` is high at a rising edge, the address register takes `bus_in[ADDR_W-1:0]`. Accesses from the following cycle onward use that address, and an access in the same cycle as the load uses the previous address.
- R2: Addresses 0 to `MEM_WORDS-1` select the memory array. `bus_load` writes `bus_in` there at the rising edge, and `bus_store` returns the stored word combinationally.
- R3: `bus_drive` follows `bus_store`. `bus_out` is zero whenever `bus_store` is low.
- R4: The slot at `DEV_BASE + k` is selected by offset k, with `DEV_BASE` a multiple of 8. The offsets are: 0 pixel X, 1 pixel Y, 2 pixel colour, 3 pointer X, 4 pointer Y, 5 screen clear, 6 key, 7 terminal character. Slots 0 to 2 are written by `bus_load`, read back by `bus_store`, and presented continuously on `pix_x`, `pix_y` and `pix_rgb`.
- R5: Slots 3, 4 and 6 return `ptr_x_in`, `ptr_y_in` and `key_in` live on a read. Writes to them change no output.
- R6: A write to slot 5 (or slot 7) puts the data on `clear_value` (or `tty_value`). In the cycle after the write edge, `clear_pulse` (or `tty_pulse`) is high for exactly one cycle. Reading either slot returns the last value written to it.
- R7: Every other address is unmapped. A read returns zero, and a write changes neither memory, any device register nor any pulse.
- R8: While `rst_n` is low, the address register, all writable device registers and both pulses are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | DATA_W | Data from the bus |
| addr_load | input | 1 | Capture address from bus |
| bus_load | input | 1 | Write bus data to the selected location |
| bus_store | input | 1 | Read the selected location onto the bus |
| bus_out | output | DATA_W | Read data, zero when not storing |
| bus_drive | output | 1 | Output enable for the bus driver |
| ptr_x_in | input | DATA_W | External pointer X |
| ptr_y_in | input | DATA_W | External pointer Y |
| key_in | input | DATA_W | External key code |
| pix_x | output | DATA_W | Pixel X register |
| pix_y | output | DATA_W | Pixel Y register |
| pix_rgb | output | DATA_W | Pixel colour register |
| clear_pulse | output | 1 | One-cycle screen-clear command |
| clear_value | output | DATA_W | Last screen-clear data |
| tty_pulse | output | 1 | One-cycle terminal character strobe |
| tty_value | output | DATA_W | Last terminal character |

## Verification
Directed traffic first fills the memory window's edges and then reads every device slot. This separates correct slot ordering from off-by-one decoding at the memory top and the device base. Random traffic then mixes address loads, writes and reads across memory, all eight slots and four unmapped addresses: just past memory, the top of the gap, just past the last slot, and all-ones. Each cycle is compared with the reference. Writes landing in read-only or unmapped locations show up as mismatches in later reads. Back-to-back writes to the strobe slots show whether each pulse lasts exactly one cycle. Pointer and key inputs change every cycle, which tells live reads apart from stale captured values.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

  localparam int unsigned NUM_SLOTS = 8;

  typedef enum logic [2:0] {
    SLOT_PIX_X   = 3'd0,
    SLOT_PIX_Y   = 3'd1,
    SLOT_PIX_RGB = 3'd2,
    SLOT_PTR_X   = 3'd3,
    SLOT_PTR_Y   = 3'd4,
    SLOT_CLEAR   = 3'd5,
    SLOT_KEY     = 3'd6,
    SLOT_TTY     = 3'd7
  } slot_e;

  // bit k set: slot k holds a register written from the bus
  localparam logic [NUM_SLOTS-1:0] SLOT_WRITABLE = 8'b1010_0111;

  // memory window: [0, words)
  function automatic logic in_mem_window(input logic [31:0] a, input logic [31:0] words);
    return a < words;
  endfunction

  // device window: [base, base + NUM_SLOTS)
  function automatic logic in_dev_window(input logic [31:0] a, input logic [31:0] base);
    return (a >= base) && (a < base + NUM_SLOTS);
  endfunction

endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode #(
  parameter int          ADDR_W    = 24,
  parameter int          MEM_WORDS = 2048,
  parameter logic [31:0] DEV_BASE  = 32'h0080_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_mem,
  output logic              hit_dev,
  output logic              hit_none,
  output logic [2:0]        slot
);
  import mmio_pkg::*;

  logic [31:0] addr_ext;

  assign addr_ext = 32'(addr);
  assign hit_mem  = in_mem_window(addr_ext, 32'(MEM_WORDS));
  assign hit_dev  = in_dev_window(addr_ext, DEV_BASE);
  assign hit_none = !(hit_mem || hit_dev);
  // device base is 8-aligned, so the low bits are the slot offset
  assign slot     = addr[2:0];

endmodule

// File: rtl/mmio_mem_array.sv
module mmio_mem_array #(
  parameter int DATA_W = 64,
  parameter int WORDS  = 2048,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wdata;
  end

  assign rdata = cells[idx];

endmodule

// File: rtl/mmio_dev_regs.sv
module mmio_dev_regs #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        slot,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ptr_x_in,
  input  logic [DATA_W-1:0] ptr_y_in,
  input  logic [DATA_W-1:0] key_in,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] pix_x,
  output logic [DATA_W-1:0] pix_y,
  output logic [DATA_W-1:0] pix_rgb,
  output logic              clear_pulse,
  output logic [DATA_W-1:0] clear_value,
  output logic              tty_pulse,
  output logic [DATA_W-1:0] tty_value
);
  import mmio_pkg::*;

  logic [DATA_W-1:0] ext_val  [NUM_SLOTS];
  logic [DATA_W-1:0] slot_val [NUM_SLOTS];

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) ext_val[i] = '0;
    ext_val[SLOT_PTR_X] = ptr_x_in;
    ext_val[SLOT_PTR_Y] = ptr_y_in;
    ext_val[SLOT_KEY]   = key_in;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (SLOT_WRITABLE[g]) begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    q <= '0;
        else if (we && slot == 3'(g))  q <= wdata;
      end
      assign slot_val[g] = q;
    end else begin : g_ro
      assign slot_val[g] = ext_val[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clear_pulse <= 1'b0;
      tty_pulse   <= 1'b0;
    end else begin
      clear_pulse <= we && (slot == SLOT_CLEAR);
      tty_pulse   <= we && (slot == SLOT_TTY);
    end
  end

  assign rdata       = slot_val[slot];
  assign pix_x       = slot_val[SLOT_PIX_X];
  assign pix_y       = slot_val[SLOT_PIX_Y];
  assign pix_rgb     = slot_val[SLOT_PIX_RGB];
  assign clear_value = slot_val[SLOT_CLEAR];
  assign tty_value   = slot_val[SLOT_TTY];

endmodule

// File: rtl/mmio_decoder.sv
module mmio_decoder #(
  parameter int          DATA_W    = 64,
  parameter int          ADDR_W    = 24,
  parameter int          MEM_WORDS = 2048,
  parameter logic [31:0] DEV_BASE  = 32'h0080_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_in,
  input  logic              addr_load,
  input  logic              bus_load,
  input  logic              bus_store,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_drive,
  input  logic [DATA_W-1:0] ptr_x_in,
  input  logic [DATA_W-1:0] ptr_y_in,
  input  logic [DATA_W-1:0] key_in,
  output logic [DATA_W-1:0] pix_x,
  output logic [DATA_W-1:0] pix_y,
  output logic [DATA_W-1:0] pix_rgb,
  output logic              clear_pulse,
  output logic [DATA_W-1:0] clear_value,
  output logic              tty_pulse,
  output logic [DATA_W-1:0] tty_value
);
  localparam int IDX_W = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;

  logic [ADDR_W-1:0] mar_q;
  logic              hit_mem, hit_dev, hit_none;
  logic [2:0]        hit_slot;
  logic              mem_we, dev_we;
  logic [DATA_W-1:0] mem_rdata, dev_rdata, rd_sel;

  // address register: loads from the bus, never drives it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mar_q <= '0;
    else if (addr_load) mar_q <= bus_in[ADDR_W-1:0];
  end

  mmio_addr_decode #(
    .ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS), .DEV_BASE(DEV_BASE)
  ) u_dec (
    .addr(mar_q), .hit_mem(hit_mem), .hit_dev(hit_dev),
    .hit_none(hit_none), .slot(hit_slot)
  );

  assign mem_we = bus_load && hit_mem;
  assign dev_we = bus_load && hit_dev;

  mmio_mem_array #(.DATA_W(DATA_W), .WORDS(MEM_WORDS)) u_mem (
    .clk(clk), .we(mem_we), .idx(mar_q[IDX_W-1:0]),
    .wdata(bus_in), .rdata(mem_rdata)
  );

  mmio_dev_regs #(.DATA_W(DATA_W)) u_dev (
    .clk(clk), .rst_n(rst_n), .we(dev_we), .slot(hit_slot), .wdata(bus_in),
    .ptr_x_in(ptr_x_in), .ptr_y_in(ptr_y_in), .key_in(key_in),
    .rdata(dev_rdata), .pix_x(pix_x), .pix_y(pix_y), .pix_rgb(pix_rgb),
    .clear_pulse(clear_pulse), .clear_value(clear_value),
    .tty_pulse(tty_pulse), .tty_value(tty_value)
  );

  always_comb begin
    rd_sel = '0;
    if (hit_mem)      rd_sel = mem_rdata;
    else if (hit_dev) rd_sel = dev_rdata;
  end

  assign bus_out   = bus_store ? rd_sel : '0;
  assign bus_drive = bus_store;

endmodule

// File: rtl/mmio_decoder_chk.sv
module mmio_decoder_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_in,
  input logic              addr_load,
  input logic              bus_load,
  input logic              bus_store,
  input logic [DATA_W-1:0] bus_out,
  input logic [DATA_W-1:0] ptr_x_in,
  input logic [DATA_W-1:0] pix_x,
  input logic              clear_pulse,
  input logic              tty_pulse,
  input logic [ADDR_W-1:0] mar_q,
  input logic              hit_mem,
  input logic              hit_dev,
  input logic              hit_none,
  input logic [2:0]        hit_slot
);

  assert_mar_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> mar_q == $past(bus_in[ADDR_W-1:0]));

  assert_quiet_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_store |-> bus_out == '0);

  assert_one_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit_mem, hit_dev, hit_none}) == 1);

  assert_unmapped_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_store && hit_none) |-> bus_out == '0);

  assert_ptr_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_store && hit_dev && hit_slot == 3'd3) |-> bus_out == ptr_x_in);

  assert_pix_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_load && hit_dev && hit_slot == 3'd0) |=> $stable(pix_x));

  assert_clear_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pulse |-> $past(bus_load && hit_dev && hit_slot == 3'd5));

  assert_tty_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tty_pulse |-> $past(bus_load && hit_dev && hit_slot == 3'd7));

endmodule

bind mmio_decoder mmio_decoder_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .addr_load(addr_load),
  .bus_load(bus_load), .bus_store(bus_store), .bus_out(bus_out),
  .ptr_x_in(ptr_x_in), .pix_x(pix_x), .clear_pulse(clear_pulse),
  .tty_pulse(tty_pulse), .mar_q(mar_q), .hit_mem(hit_mem), .hit_dev(hit_dev),
  .hit_none(hit_none), .hit_slot(hit_slot)
);

// File: tb/tb_mmio_decoder.sv
`timescale 1ns/1ps
module tb_mmio_decoder;
  localparam int          DW    = 64;
  localparam int          AW    = 24;
  localparam int          WORDS = 64;
  localparam logic [31:0] BASE  = 32'h0080_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] bus_in = '0;
  logic addr_load = 1'b0, bus_load = 1'b0, bus_store = 1'b0;
  logic [DW-1:0] ptr_x_in = '0, ptr_y_in = '0, key_in = '0;
  logic [DW-1:0] bus_out, pix_x, pix_y, pix_rgb, clear_value, tty_value;
  logic bus_drive, clear_pulse, tty_pulse;

  always #2.5 clk = ~clk;

  mmio_decoder #(.DATA_W(DW), .ADDR_W(AW), .MEM_WORDS(WORDS), .DEV_BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .addr_load(addr_load),
    .bus_load(bus_load), .bus_store(bus_store), .bus_out(bus_out),
    .bus_drive(bus_drive), .ptr_x_in(ptr_x_in), .ptr_y_in(ptr_y_in),
    .key_in(key_in), .pix_x(pix_x), .pix_y(pix_y), .pix_rgb(pix_rgb),
    .clear_pulse(clear_pulse), .clear_value(clear_value),
    .tty_pulse(tty_pulse), .tty_value(tty_value));

  // ---------------- reference model ----------------
  int unsigned m_addr;
  logic [DW-1:0] m_mem [int unsigned];
  logic [DW-1:0] m_dev [8];
  bit m_clr, m_tty;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = 0; m_clr = 0; m_tty = 0;
      for (int i = 0; i < 8; i++) m_dev[i] = '0;
    end else begin
      m_clr = 0; m_tty = 0;
      if (bus_load) begin
        if (m_addr < WORDS) m_mem[m_addr] = bus_in;
        else if (m_addr >= BASE && m_addr < BASE + 8) begin
          case (m_addr - BASE)
            0, 1, 2: m_dev[m_addr - BASE] = bus_in;
            5: begin m_dev[5] = bus_in; m_clr = 1; end
            7: begin m_dev[7] = bus_in; m_tty = 1; end
            default: ;
          endcase
        end
      end
      if (addr_load) m_addr = int'(bus_in[AW-1:0]);
    end
  end

  int compared = 0, mismatched = 0;
  bit finished = 0;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every output against the model
  task automatic compare_all(string force_tag);
    string t;
    logic [DW-1:0] e;
    bit known;
    known = 1; e = '0;
    if (!bus_store) t = "R3";
    else if (m_addr < WORDS) begin
      t = "R2";
      if (m_mem.exists(m_addr)) e = m_mem[m_addr]; else known = 0;
    end else if (m_addr >= BASE && m_addr < BASE + 8) begin
      case (m_addr - BASE)
        3: begin t = "R5"; e = ptr_x_in; end
        4: begin t = "R5"; e = ptr_y_in; end
        6: begin t = "R5"; e = key_in; end
        5, 7: begin t = "R6"; e = m_dev[m_addr - BASE]; end
        default: begin t = "R4"; e = m_dev[m_addr - BASE]; end
      endcase
    end else t = "R7";
    if (force_tag != "") t = force_tag;
    if (known) chk(t, bus_out, e);
    chk("R3", DW'(bus_drive), DW'(bus_store));
    chk("R4", pix_x, m_dev[0]);
    chk("R4", pix_y, m_dev[1]);
    chk("R4", pix_rgb, m_dev[2]);
    chk("R6", DW'(clear_pulse), DW'(m_clr));
    chk("R6", clear_value, m_dev[5]);
    chk("R6", DW'(tty_pulse), DW'(m_tty));
    chk("R6", tty_value, m_dev[7]);
  endtask

  task automatic step(bit al, bit ld, bit st, logic [DW-1:0] d, string tag);
    addr_load = al; bus_load = ld; bus_store = st; bus_in = d;
    ptr_x_in = {$urandom, $urandom}; ptr_y_in = {$urandom, $urandom};
    key_in = DW'($urandom);
    #1 compare_all(tag);
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] pick_addr(int k);
    case (k % 16)
      0, 1, 2:  return DW'(k % 8);
      3:        return DW'(WORDS - 1);
      4:        return DW'(WORDS);            // just past memory: unmapped
      5:        return DW'(BASE - 1);         // top of gap: unmapped
      6:        return DW'(BASE + 8);         // past last slot: unmapped
      7:        return DW'(24'hFF_FFFF);      // all ones: unmapped
      default:  return DW'(BASE + (k % 8));
    endcase
  endfunction

  initial begin
    @(negedge clk); @(negedge clk);
    // R8: reset state
    chk("R8", pix_x | pix_y | pix_rgb | clear_value | tty_value, '0);
    chk("R8", DW'({clear_pulse, tty_pulse}), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: fill memory edges (R2), R1 same-cycle load uses old address
    for (int a = 0; a < 8; a++) begin
      step(1, 0, 0, DW'(a), "");
      step(0, 1, 0, 64'hA5A5_0000_0000_0000 | DW'(a), "");
    end
    step(1, 0, 0, DW'(WORDS - 1), "");
    step(0, 1, 0, 64'hDEAD_BEEF_0000_0003, "");
    step(1, 0, 0, DW'(3), "");
    step(0, 0, 1, '0, "R1");
    step(1, 0, 1, DW'(WORDS - 1), "R1");   // read still from address 3
    step(0, 0, 1, '0, "R1");               // now from WORDS-1

    // directed: every device slot written, then read (R4, R5, R6)
    for (int s = 0; s < 8; s++) begin
      step(1, 0, 0, DW'(BASE + s), "");
      step(0, 1, 0, 64'h1111_0000_0000_0000 | DW'(s * 17), "");
      step(0, 1, 0, 64'h2222_0000_0000_0000 | DW'(s), "");   // back-to-back write
      step(0, 0, 1, '0, "");
    end
    // unmapped write then neighbouring reads (R7)
    step(1, 0, 0, DW'(WORDS), "");
    step(0, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    step(1, 0, 0, DW'(0), "");
    step(0, 0, 1, '0, "R7");

    // random traffic compared every cycle
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: step(1, 0, 0, pick_addr(int'($urandom % 64)), "");
        1: step(0, 1, 0, {$urandom, $urandom}, "");
        2: step(0, 0, 1, '0, "");
        default: step(0, 1, 1, {$urandom, $urandom}, "");
      endcase
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule